// File: doc/BRIEF.md
# DDR1 Power-Up Command Sequencer

This block brings a DDR1 SDRAM device from "clock enable just raised" to "safe to read". Once it sees the clock-enable indication high, it plays out a fixed initialisation program one command per clock. The program covers:

- idle cycles;
- two precharge-all operations that bracket the mode programming;
- an extended mode write;
- a base mode write that resets the DLL, and a later base mode write that releases it;
- two auto-refresh operations, each padded with NOPs for the refresh recovery time.

Every cycle it drives a command code on the chip-select, row-strobe, column-strobe and write-enable lines, together with a bank address and a row address.

A separate counter starts when the DLL-reset mode write goes out. The ready output rises only when the program has finished and that counter has covered the DLL lock interval. Ready then stays high until reset. The program runs once per reset. The memory controller holds off all read traffic until ready is high.

Top module: `ddr_init_seq`

## Requirements
- R1: In reset, and while idle with cke_i low, the outputs are: command NOP (cs_n, ras_n, cas_n, we_n = 4'b0111), bank 0, address 0, and ready_o low. Only the codes NOP, PRECHARGE (4'b0010), REFRESH (4'b0001) and MODE SET (4'b0000) ever appear.
- R2: The first clock edge that samples cke_i high starts the program, and the command output changes at that same edge. The first ten commands are NOPs. The eleventh is PRECHARGE with address bit 10 high, all other address bits 0 and bank 0, followed by one NOP.
- R3: Next comes MODE SET to the extended register: bank 1, address equal to the extended-mode parameter. One NOP follows it.
- R4: Next comes MODE SET to the base register: bank 0, address equal to the base-mode parameter with bit 8 (DLL reset) forced to 1. One NOP follows it.
- R5: Next comes a second PRECHARGE with address bit 10 high and bank 0, followed by one NOP.
- R6: Next come two groups. Each group is one REFRESH (address 0, bank 0) followed by eight NOPs.
- R7: Next comes MODE SET to the base register: bank 0, address equal to the base-mode parameter with bit 8 forced to 0. One NOP follows it, and after that the output is NOP on every cycle.
- R8: ready_o rises on the later of two points: the cycle after the final NOP, or exactly 200 cycles after the cycle that carries the DLL-reset mode write. With the default settings this is 200 cycles after that write.
- R9: Once started, the program ignores cke_i: dropping it changes neither the command stream nor ready_o. After ready_o rises it stays high until reset, and the program never runs a second time.
- R10: Reset applied part-way through the program returns the outputs to the R1 state at once. The next clock edge that samples cke_i high then starts the full program from its first NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM command clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | High once the device clock enable has been raised |
| cmd_o | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| ba_o | output | BA_W | Bank address (selects the base or extended mode register) |
| addr_o | output | ADDR_W | Row address / mode-register value |
| ready_o | output | 1 | Initialisation complete and DLL lock interval elapsed |

## Verification
The bench runs a behavioural model that holds a queue of the expected commands. It compares the command, bank, address and ready outputs against that model on every cycle, so an off-by-one in any NOP pad shows up as a misplaced PRECHARGE, REFRESH or MODE SET.

The lock window is measured directly, from the DLL-reset write seen on the pins to the first ready cycle. A timer that started one write too late, or that counted from the end of the program, would report a distance other than 200.

Two further cases are covered. Dropping cke_i mid-program exposes a sequencer that stalls or restarts on the enable. A reset mid-program, followed by a fresh start, exposes state that survives reset, such as a stale lock count that would raise ready early.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } ddr_cmd_e;

    typedef enum logic [2:0] {
        STEP_NOP,
        STEP_PREA,
        STEP_EMRS,
        STEP_MRS_DLLRST,
        STEP_MRS_RUN,
        STEP_REF
    } step_kind_e;

    // Each operation is one command plus its trailing NOP pad.
    function automatic int unsigned seq_len(
        input int unsigned pre_nops,
        input int unsigned trp_nops,
        input int unsigned tmrd_nops,
        input int unsigned trfc_nops,
        input int unsigned ref_groups
    );
        return pre_nops
             + 2 * (1 + trp_nops)
             + 3 * (1 + tmrd_nops)
             + ref_groups * (1 + trfc_nops);
    endfunction

endpackage

// File: rtl/ddr_init_step_rom.sv
module ddr_init_step_rom
    import ddr_init_pkg::*;
#(
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned PRE_NOPS   = 10,
    parameter int unsigned TRP_NOPS   = 1,
    parameter int unsigned TMRD_NOPS  = 1,
    parameter int unsigned TRFC_NOPS  = 8,
    parameter int unsigned REF_GROUPS = 2
) (
    input  logic [IDX_W-1:0] idx_i,
    output step_kind_e       kind_o
);

    localparam int unsigned B_PRE1    = PRE_NOPS;
    localparam int unsigned B_EMRS    = B_PRE1 + 1 + TRP_NOPS;
    localparam int unsigned B_MRS_DLL = B_EMRS + 1 + TMRD_NOPS;
    localparam int unsigned B_PRE2    = B_MRS_DLL + 1 + TMRD_NOPS;
    localparam int unsigned B_REF     = B_PRE2 + 1 + TRP_NOPS;
    localparam int unsigned REF_GRP   = 1 + TRFC_NOPS;
    localparam int unsigned B_MRS_RUN = B_REF + REF_GROUPS * REF_GRP;

    logic [REF_GROUPS-1:0] ref_hit;

    // One comparator per refresh group, each at its own start slot.
    for (genvar g = 0; g < REF_GROUPS; g++) begin : g_ref_slot
        assign ref_hit[g] = (idx_i == IDX_W'(B_REF + g * REF_GRP));
    end

    always_comb begin
        kind_o = STEP_NOP;
        if (idx_i == IDX_W'(B_PRE1) || idx_i == IDX_W'(B_PRE2)) begin
            kind_o = STEP_PREA;
        end else if (idx_i == IDX_W'(B_EMRS)) begin
            kind_o = STEP_EMRS;
        end else if (idx_i == IDX_W'(B_MRS_DLL)) begin
            kind_o = STEP_MRS_DLLRST;
        end else if (idx_i == IDX_W'(B_MRS_RUN)) begin
            kind_o = STEP_MRS_RUN;
        end else if (|ref_hit) begin
            kind_o = STEP_REF;
        end
    end

endmodule

// File: rtl/ddr_init_cmd_enc.sv
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned BA_W        = 2,
    parameter int unsigned MR_VAL      = 32'h0000_0022,
    parameter int unsigned EMR_VAL     = 32'h0000_0000,
    parameter int unsigned DLL_RST_BIT = 8,
    parameter int unsigned AP_BIT      = 10
) (
    input  step_kind_e        kind_i,
    output ddr_cmd_e          cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        unique case (kind_i)
            STEP_PREA: begin
                cmd_o          = CMD_PRE;
                addr_o[AP_BIT] = 1'b1;
            end
            STEP_EMRS: begin
                cmd_o  = CMD_MRS;
                ba_o   = BA_W'(1);
                addr_o = ADDR_W'(EMR_VAL);
            end
            STEP_MRS_DLLRST: begin
                cmd_o               = CMD_MRS;
                addr_o              = ADDR_W'(MR_VAL);
                addr_o[DLL_RST_BIT] = 1'b1;
            end
            STEP_MRS_RUN: begin
                cmd_o               = CMD_MRS;
                addr_o              = ADDR_W'(MR_VAL);
                addr_o[DLL_RST_BIT] = 1'b0;
            end
            STEP_REF: cmd_o = CMD_REF;
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_init_lock_timer.sv
module ddr_init_lock_timer #(
    parameter int unsigned LOCK_CYC = 200
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic elapsed_o
);

    localparam int unsigned CNT_W = $clog2(LOCK_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYC - 1);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (start_i) begin
            t_d.armed = 1'b1;
            t_d.cnt   = '0;
        end else if (t_q.armed && t_q.cnt != CNT_LAST) begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign elapsed_o = t_q.armed && (t_q.cnt == CNT_LAST);

    assert_lock_cnt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        t_q.cnt <= CNT_LAST);

    assert_lock_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (elapsed_o && !start_i) |=> elapsed_o);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned BA_W        = 2,
    parameter int unsigned PRE_NOPS    = 10,
    parameter int unsigned TRP_NOPS    = 1,
    parameter int unsigned TMRD_NOPS   = 1,
    parameter int unsigned TRFC_NOPS   = 8,
    parameter int unsigned REF_GROUPS  = 2,
    parameter int unsigned LOCK_CYC    = 200,
    parameter int unsigned MR_VAL      = 32'h0000_0022,
    parameter int unsigned EMR_VAL     = 32'h0000_0000,
    parameter int unsigned DLL_RST_BIT = 8,
    parameter int unsigned AP_BIT      = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cke_i,
    output logic [3:0]        cmd_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              ready_o
);

    localparam int unsigned NUM_STEPS =
        seq_len(PRE_NOPS, TRP_NOPS, TMRD_NOPS, TRFC_NOPS, REF_GROUPS);
    localparam int unsigned IDX_W = $clog2(NUM_STEPS + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_STEPS);

    typedef struct packed {
        logic              run;
        logic              done;
        logic [IDX_W-1:0]  idx;
        logic [3:0]        cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              ready;
    } seq_state_t;

    seq_state_t        s_d, s_q;
    logic [IDX_W-1:0]  idx_sel;
    logic              issue;
    logic              seq_end;
    logic              lock_start;
    logic              lock_elapsed;
    step_kind_e        step_kind;
    ddr_cmd_e          enc_cmd;
    logic [BA_W-1:0]   enc_ba;
    logic [ADDR_W-1:0] enc_addr;

    ddr_init_step_rom #(
        .IDX_W      (IDX_W),
        .PRE_NOPS   (PRE_NOPS),
        .TRP_NOPS   (TRP_NOPS),
        .TMRD_NOPS  (TMRD_NOPS),
        .TRFC_NOPS  (TRFC_NOPS),
        .REF_GROUPS (REF_GROUPS)
    ) u_rom (
        .idx_i  (idx_sel),
        .kind_o (step_kind)
    );

    ddr_init_cmd_enc #(
        .ADDR_W      (ADDR_W),
        .BA_W        (BA_W),
        .MR_VAL      (MR_VAL),
        .EMR_VAL     (EMR_VAL),
        .DLL_RST_BIT (DLL_RST_BIT),
        .AP_BIT      (AP_BIT)
    ) u_enc (
        .kind_i (step_kind),
        .cmd_o  (enc_cmd),
        .ba_o   (enc_ba),
        .addr_o (enc_addr)
    );

    ddr_init_lock_timer #(
        .LOCK_CYC (LOCK_CYC)
    ) u_lock (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (lock_start),
        .elapsed_o (lock_elapsed)
    );

    always_comb begin
        s_d     = s_q;
        issue   = 1'b0;
        idx_sel = s_q.idx;
        s_d.cmd  = CMD_NOP;
        s_d.ba   = '0;
        s_d.addr = '0;
        if (s_q.run) begin
            if (s_q.idx == IDX_END) begin
                s_d.run  = 1'b0;
                s_d.done = 1'b1;
            end else begin
                issue   = 1'b1;
                s_d.idx = s_q.idx + 1'b1;
            end
        end else if (!s_q.done && cke_i) begin
            issue   = 1'b1;
            idx_sel = '0;
            s_d.run = 1'b1;
            s_d.idx = IDX_W'(1);
        end
        if (issue) begin
            s_d.cmd  = enc_cmd;
            s_d.ba   = enc_ba;
            s_d.addr = enc_addr;
        end
        lock_start = issue && (step_kind == STEP_MRS_DLLRST);
        seq_end    = s_q.done || (s_q.run && s_q.idx == IDX_END);
        s_d.ready  = s_q.ready || (seq_end && lock_elapsed);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q     <= '0;
            s_q.cmd <= CMD_NOP;
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_o   = s_q.cmd;
    assign ba_o    = s_q.ba;
    assign addr_o  = s_q.addr;
    assign ready_o = s_q.ready;

    assert_cmd_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_o == CMD_NOP || cmd_o == CMD_PRE || cmd_o == CMD_REF || cmd_o == CMD_MRS);

    assert_idle_nop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.run && !s_q.done) |-> (cmd_o == CMD_NOP && !ready_o));

    assert_prea_ap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_PRE) |-> (addr_o[AP_BIT] && ba_o == '0));

    assert_ref_pad_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_o == CMD_REF) |=> (cmd_o == CMD_NOP));

    assert_tail_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.done |-> (cmd_o == CMD_NOP));

    assert_ready_after_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> s_q.done);

    assert_ready_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> $past(lock_elapsed));

    assert_ready_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> ready_o);

endmodule

// File: tb/sim_ddr_init_seq.sv
`timescale 1ns/1ps
module sim_ddr_init_seq;

    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int LOCK   = 200;
    localparam logic [ADDR_W-1:0] MR_BASE = 13'h022;
    localparam logic [ADDR_W-1:0] EMR     = 13'h000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cke;
    logic [3:0]        cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic              ready;

    always #2 clk = ~clk;

    ddr_init_seq u0 (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .cke_i   (cke),
        .cmd_o   (cmd),
        .ba_o    (ba),
        .addr_o  (addr),
        .ready_o (ready)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [3:0]        q_cmd[$];
    logic [BA_W-1:0]   q_ba[$];
    logic [ADDR_W-1:0] q_addr[$];
    int                q_tag[$];
    bit                q_dll[$];

    task automatic push(input logic [3:0] c, input logic [BA_W-1:0] b,
                        input logic [ADDR_W-1:0] a, input int tag, input bit dll);
        q_cmd.push_back(c); q_ba.push_back(b); q_addr.push_back(a);
        q_tag.push_back(tag); q_dll.push_back(dll);
    endtask

    task automatic push_nops(input int n, input int tag);
        for (int i = 0; i < n; i++) push(4'b0111, '0, '0, tag, 1'b0);
    endtask

    task automatic build_program();
        push_nops(10, 2);                                  // R2: lead-in NOPs
        push(4'b0010, '0, 13'h400, 2, 1'b0); push_nops(1, 2); // R2: precharge all
        push(4'b0000, 2'd1, EMR, 3, 1'b0);   push_nops(1, 3); // R3: extended mode
        push(4'b0000, 2'd0, MR_BASE | 13'h100, 4, 1'b1);      // R4: DLL reset
        push_nops(1, 4);
        push(4'b0010, '0, 13'h400, 5, 1'b0); push_nops(1, 5); // R5: second precharge
        for (int g = 0; g < 2; g++) begin                     // R6: refresh groups
            push(4'b0001, '0, '0, 6, 1'b0); push_nops(8, 6);
        end
        push(4'b0000, 2'd0, MR_BASE & ~13'h100, 7, 1'b0);     // R7: DLL released
        push_nops(1, 7);
    endtask

    // Behavioural reference, advanced on each rising edge
    bit m_started = 0;
    int m_pos     = 0;
    bit m_dll     = 0;
    int m_age     = 0;
    bit m_ready   = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_pos = 0; m_dll = 0; m_age = 0; m_ready = 0;
        end else begin
            if (m_started) m_pos++;
            else if (cke) begin m_started = 1; m_pos = 0; end
            if (m_dll) m_age++;
            if (m_started && m_pos < q_cmd.size() && q_dll[m_pos]) begin
                m_dll = 1; m_age = 0;
            end
            if (m_started && m_pos >= q_cmd.size() && m_dll && m_age >= LOCK)
                m_ready = 1;
        end
    end

    task automatic check(input bit ok, input int tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Measured DLL-reset-to-ready distance (R8)
    int  dll_cyc   = -1;
    int  ready_cyc = -1;
    bit  prev_rdy  = 0;

    always @(negedge clk) begin
        logic [3:0]        e_cmd;
        logic [BA_W-1:0]   e_ba;
        logic [ADDR_W-1:0] e_addr;
        bit                e_rdy;
        int                tag;
        e_cmd = 4'b0111; e_ba = '0; e_addr = '0; tag = 1; e_rdy = 0;
        if (rst_n) begin
            e_rdy = m_ready;
            if (m_started) begin
                if (m_pos < q_cmd.size()) begin
                    e_cmd = q_cmd[m_pos]; e_ba = q_ba[m_pos];
                    e_addr = q_addr[m_pos]; tag = q_tag[m_pos];
                end else begin
                    tag = 7;
                end
            end
        end
        check({cmd, ba, addr} === {e_cmd, e_ba, e_addr}, tag, "cmd/ba/addr",
              32'({cmd, ba, addr}), 32'({e_cmd, e_ba, e_addr}));
        check(ready === e_rdy, 8, "ready", 32'(ready), 32'(e_rdy));
        if (!rst_n) begin
            dll_cyc = -1; ready_cyc = -1; prev_rdy = 0;
        end else begin
            if (cmd == 4'b0000 && ba == 2'd0 && addr[8]) dll_cyc = cyc;
            if (ready && !prev_rdy) ready_cyc = cyc;
            prev_rdy = ready;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected below 5000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        build_program();
        rst_n = 1'b0;
        cke   = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(5);                          // R1: idle with cke low
        cke = 1'b1;
        step(20);
        cke = 1'b0;                       // R9: enable drop mid-program is ignored
        for (int i = 0; i < 400 && !ready; i++) step(1);
        step(10);
        check(ready === 1'b1, 9, "ready held with cke low", 32'(ready), 32'd1);
        check(ready_cyc - dll_cyc == LOCK, 8, "DLL-reset to ready distance",
              32'(ready_cyc - dll_cyc), 32'(LOCK));
        cke = 1'b1;
        step(5);
        check(cmd === 4'b0111, 9, "no second run", 32'(cmd), 32'h7);

        rst_n = 1'b0;                     // R10: reset after completion
        @(negedge clk);
        check({cmd, ba, addr, ready} === {4'b0111, 2'b00, 13'h0, 1'b0}, 10,
              "reset state", 32'({cmd, ba, addr, ready}), 32'({4'b0111, 15'h0, 1'b0}));
        step(1);
        rst_n = 1'b1;
        step(30);                         // R10: reset mid-program
        rst_n = 1'b0;
        @(negedge clk);
        check({cmd, ready} === {4'b0111, 1'b0}, 10, "mid-program reset",
              32'({cmd, ready}), 32'({4'b0111, 1'b0}));
        step(2);
        rst_n = 1'b1;
        for (int i = 0; i < 400 && !ready; i++) step(1);
        step(5);
        check(ready === 1'b1, 10, "restart completes", 32'(ready), 32'd1);
        check(ready_cyc - dll_cyc == LOCK, 10, "restart lock distance",
              32'(ready_cyc - dll_cyc), 32'(LOCK));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule